// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames from a byte stream into host memory buffers. The host owns a ring of receive descriptors. Each descriptor holds a status word and a buffer base address. The engine reads the descriptor at its current ring position before a frame arrives, and uses it only if the host has marked it free (the empty bit is set). When a frame starts, the engine writes each byte to consecutive buffer addresses through a registered memory write port. At the end of the frame it writes back the byte count and an error status, clears the empty bit, and raises a one-cycle completion pulse. It then moves to the next ring position, or back to position 0 when the descriptor it just filled carried the wrap bit.

When the next descriptor is still owned by the host, the engine parks and stops reading descriptors. It resumes after the host returns buffers and writes the restart word to the activity register. A frame that starts while no free descriptor is armed is discarded and counted. The byte count includes the four trailing check bytes of the frame. A frame longer than the buffer is cut at the buffer size and flagged. Integrity and error checks are made upstream, and their results arrive as flags with the last byte.

The state machine has six states:

| State | What it does |
|---|---|
| PARK | Waits for a restart. |
| FETCH | Issues a descriptor read. |
| LOOK | Takes the read data and tests the empty bit. |
| ARMED | Holds a free descriptor and waits for a frame start. |
| RECV | Stores bytes until the frame ends. |
| WBACK | Writes back the descriptor, then advances the ring. |

The transitions are:

- PARK→FETCH on restart.
- FETCH→LOOK always.
- LOOK→ARMED if the descriptor is empty.
- LOOK→FETCH if the descriptor is not empty and a restart arrived meanwhile.
- LOOK→PARK if the descriptor is not empty and no restart arrived.
- ARMED→RECV on a start byte that is not also the last byte.
- ARMED→WBACK on a single-byte frame.
- RECV→WBACK on the end byte.
- WBACK→FETCH always.

Top module: `rxd_engine`

## Requirements
- R1: After reset the engine is in PARK with ring position 0, no descriptor read, no descriptor or memory write, completion low and the missed count 0. It issues no descriptor read until a restart.
- R2: A restart is an activity write whose data equals 32'h0100_0000. Any other written value has no effect, and a restart seen while PARK is left causes a descriptor read.
- R3: A descriptor is filled only if bit 15 (empty) of its status is 1. If it is 0, the engine parks and the frames that follow are not stored.
- R4: The bytes of a frame are written in order to buffer base + 0, 1, 2, …, one write per stored byte. Each write appears one cycle after the byte is accepted.
- R5: The written-back length is the number of bytes of the frame, including its last four check bytes.
- R6: Bytes beyond BUF_MAX are not written. The length is then BUF_MAX and status bit 0 (truncated) is 1. A frame of exactly BUF_MAX bytes is not flagged.
- R7: The written-back status has bit 15 cleared, bits 5:1 equal to the error flags given with the end byte, bit 0 as in R6, and every other bit equal to the fetched status word. Bits 5:0 all zero mean a good frame.
- R8: After each write-back the ring position advances by one. It returns to 0 instead when status bit 13 (wrap) of the filled descriptor is 1.
- R9: A frame whose start byte arrives in any state other than ARMED or RECV is discarded. It causes no memory write and increments a saturating missed-frame count by one.
- R10: The completion pulse is high for exactly the one cycle after each descriptor write-back cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte present on rx_data |
| rx_data | input | 8 | Frame byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_err | input | 5 | Error flags, valid with the last byte |
| act_wr_en | input | 1 | Host write to the activity register |
| act_wr_data | input | 32 | Value of that write |
| desc_rd_en | output | 1 | Descriptor read request |
| desc_rd_idx | output | IDX_W | Ring position read |
| desc_rd_status | input | 16 | Status word, valid the cycle after the request |
| desc_rd_buf | input | ADDR_W | Buffer base, valid the cycle after the request |
| desc_wr_en | output | 1 | Descriptor write-back |
| desc_wr_idx | output | IDX_W | Ring position written |
| desc_wr_status | output | 16 | Status written back |
| desc_wr_len | output | 16 | Length written back |
| mem_wr_en | output | 1 | Buffer byte write |
| mem_wr_addr | output | ADDR_W | Byte address |
| mem_wr_data | output | 8 | Byte value |
| frame_done | output | 1 | Completion pulse |
| missed_count | output | MISS_W | Discarded frame count, saturating |

## Verification
The bench sweeps the frame length through every value from 1 to well past a 48-byte buffer. Each length is paired with a different error-flag pattern and a byte pattern computed from the frame and the offset. The sweep separates correct counting from truncation, and finds off-by-one errors at the buffer limit and the single-byte frame. It also finds stray or misplaced buffer writes. Because the sweep runs through the ring many times, and every descriptor past the wrap point is left non-empty, it exposes an index that ignores the wrap bit. Separate drop patterns cover frames before any restart, after restart writes with wrong values, and with every descriptor held by the host. These patterns separate ownership and restart handling from the missed-count saturation.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int STAT_W    = 16;
    localparam int LENF_W    = 16;
    localparam int ERR_IN_W  = 5;

    localparam int EMPTY_BIT = 15;
    localparam int WRAP_BIT  = 13;
    localparam int TRUNC_BIT = 0;
    localparam int ERR_LSB   = 1;

    localparam logic [31:0] RESTART_WORD = 32'h0100_0000;

    typedef enum logic [2:0] {
        S_PARK,
        S_FETCH,
        S_LOOK,
        S_ARMED,
        S_RECV,
        S_WBACK
    } rxd_state_e;

endpackage

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             wrap,
    output logic [IDX_W-1:0] idx
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (advance) begin
            if (wrap) idx <= '0;
            else      idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/rxd_byte_writer.sv
module rxd_byte_writer #(
    parameter int ADDR_W  = 32,
    parameter int BUF_MAX = 1520
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              first,
    input  logic [7:0]        byte_in,
    input  logic [ADDR_W-1:0] base,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic [15:0]       len,
    output logic              trunc
);

    localparam int CNT_W = $clog2(BUF_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] slot;
    logic             room;

    always_comb begin
        slot = first ? '0 : cnt;
        room = (int'(slot) < BUF_MAX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            trunc   <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (take) begin
                trunc <= first ? 1'b0 : (trunc | ~room);
                if (room) begin
                    wr_en   <= 1'b1;
                    wr_addr <= base + ADDR_W'(slot);
                    wr_data <= byte_in;
                    cnt     <= slot + 1'b1;
                end
            end
        end
    end

    assign len = 16'(cnt);

endmodule

// File: rtl/rxd_miss_counter.sv
module rxd_miss_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bump,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (bump && (count != {W{1'b1}})) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
    import rxd_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 3,
    parameter int BUF_MAX = 1520,
    parameter int MISS_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_valid,
    input  logic [7:0]          rx_data,
    input  logic                rx_sof,
    input  logic                rx_eof,
    input  logic [4:0]          rx_err,
    input  logic                act_wr_en,
    input  logic [31:0]         act_wr_data,
    output logic                desc_rd_en,
    output logic [IDX_W-1:0]    desc_rd_idx,
    input  logic [15:0]         desc_rd_status,
    input  logic [ADDR_W-1:0]   desc_rd_buf,
    output logic                desc_wr_en,
    output logic [IDX_W-1:0]    desc_wr_idx,
    output logic [15:0]         desc_wr_status,
    output logic [15:0]         desc_wr_len,
    output logic                mem_wr_en,
    output logic [ADDR_W-1:0]   mem_wr_addr,
    output logic [7:0]          mem_wr_data,
    output logic                frame_done,
    output logic [MISS_W-1:0]   missed_count
);

    rxd_state_e state, state_nx;

    logic                restart;
    logic                restart_pend;
    logic                sof_seen;
    logic                start_ok;
    logic                take;
    logic                drop_start;
    logic [STAT_W-1:0]   cur_status;
    logic [ADDR_W-1:0]   cur_buf;
    logic [ERR_IN_W-1:0] err_q;
    logic [IDX_W-1:0]    ring_idx;
    logic [15:0]         fill_len;
    logic                fill_trunc;

    always_comb begin
        restart    = act_wr_en && (act_wr_data == RESTART_WORD);
        sof_seen   = rx_valid && rx_sof;
        start_ok   = (state == S_ARMED) && sof_seen;
        take       = start_ok || ((state == S_RECV) && rx_valid);
        drop_start = sof_seen && (state != S_ARMED) && (state != S_RECV);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_PARK;
        else        state <= state_nx;
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            S_PARK:  if (restart) state_nx = S_FETCH;
            S_FETCH: state_nx = S_LOOK;
            S_LOOK: begin
                if (desc_rd_status[EMPTY_BIT])           state_nx = S_ARMED;
                else if (restart_pend || restart)        state_nx = S_FETCH;
                else                                     state_nx = S_PARK;
            end
            S_ARMED: if (sof_seen) state_nx = rx_eof ? S_WBACK : S_RECV;
            S_RECV:  if (rx_valid && rx_eof) state_nx = S_WBACK;
            S_WBACK: state_nx = S_FETCH;
            default: state_nx = S_PARK;
        endcase
    end

    // output decode
    always_comb begin
        desc_rd_en     = (state == S_FETCH);
        desc_rd_idx    = ring_idx;
        desc_wr_en     = (state == S_WBACK);
        desc_wr_idx    = ring_idx;
        desc_wr_len    = fill_len;
        desc_wr_status = cur_status;
        desc_wr_status[EMPTY_BIT] = 1'b0;
        desc_wr_status[ERR_LSB +: ERR_IN_W] = err_q;
        desc_wr_status[TRUNC_BIT] = fill_trunc;
    end

    // descriptor, error and handshake registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_status   <= '0;
            cur_buf      <= '0;
            err_q        <= '0;
            restart_pend <= 1'b0;
            frame_done   <= 1'b0;
        end else begin
            frame_done <= (state == S_WBACK);
            if (state == S_LOOK) begin
                cur_status <= desc_rd_status;
                cur_buf    <= desc_rd_buf;
            end
            if (take && rx_eof) err_q <= rx_err;
            if (state == S_FETCH)     restart_pend <= restart;
            else if (state != S_PARK) restart_pend <= restart_pend | restart;
        end
    end

    rxd_ring_ptr #(
        .IDX_W(IDX_W)
    ) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(state == S_WBACK),
        .wrap   (cur_status[WRAP_BIT]),
        .idx    (ring_idx)
    );

    rxd_byte_writer #(
        .ADDR_W (ADDR_W),
        .BUF_MAX(BUF_MAX)
    ) u_writer (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .first  (start_ok),
        .byte_in(rx_data),
        .base   (cur_buf),
        .wr_en  (mem_wr_en),
        .wr_addr(mem_wr_addr),
        .wr_data(mem_wr_data),
        .len    (fill_len),
        .trunc  (fill_trunc)
    );

    rxd_miss_counter #(
        .W(MISS_W)
    ) u_miss (
        .clk  (clk),
        .rst_n(rst_n),
        .bump (drop_start),
        .count(missed_count)
    );

endmodule

// File: rtl/rxd_engine_checker.sv
module rxd_engine_checker #(
    parameter int IDX_W   = 3,
    parameter int BUF_MAX = 1520,
    parameter int MISS_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              desc_rd_en,
    input logic [IDX_W-1:0]  desc_rd_idx,
    input logic              desc_wr_en,
    input logic [15:0]       desc_wr_status,
    input logic [15:0]       desc_wr_len,
    input logic              frame_done,
    input logic [MISS_W-1:0] missed_count
);

    a_r3_wb_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr_en |-> !desc_wr_status[15]);

    a_r3_read_write_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_rd_en && desc_wr_en));

    a_r6_len_capped: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr_en |-> (desc_wr_len <= 16'(BUF_MAX)));

    a_r6_trunc_at_full: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_wr_en && desc_wr_status[0]) |-> (desc_wr_len == 16'(BUF_MAX)));

    a_r10_done_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr_en |=> frame_done);

    a_r10_done_only_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(desc_wr_en));

    a_r9_miss_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (missed_count != $past(missed_count)) |->
            (missed_count == $past(missed_count) + MISS_W'(1)));

    a_r8_idx_moves_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(desc_wr_en) |-> $stable(desc_rd_idx));

endmodule

bind rxd_engine rxd_engine_checker #(
    .IDX_W  (IDX_W),
    .BUF_MAX(BUF_MAX),
    .MISS_W (MISS_W)
) u_rxd_chk (.*);

// File: tb/rxd_engine_bench.sv
`timescale 1ns/1ps
module rxd_engine_bench;

    localparam int ADDR_W = 32;
    localparam int IDX_W  = 3;
    localparam int BMAX   = 48;
    localparam int MISS_W = 2;
    localparam int RING   = 4;
    localparam int SPAN   = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_data = '0;
    logic              rx_sof = 1'b0;
    logic              rx_eof = 1'b0;
    logic [4:0]        rx_err = '0;
    logic              act_wr_en = 1'b0;
    logic [31:0]       act_wr_data = '0;
    logic              desc_rd_en;
    logic [IDX_W-1:0]  desc_rd_idx;
    logic [15:0]       desc_rd_status;
    logic [ADDR_W-1:0] desc_rd_buf;
    logic              desc_wr_en;
    logic [IDX_W-1:0]  desc_wr_idx;
    logic [15:0]       desc_wr_status;
    logic [15:0]       desc_wr_len;
    logic              mem_wr_en;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [7:0]        mem_wr_data;
    logic              frame_done;
    logic [MISS_W-1:0] missed_count;

    always #4 clk = ~clk;

    rxd_engine #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BUF_MAX(BMAX), .MISS_W(MISS_W)
    ) u_rxd_engine (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
        .act_wr_en(act_wr_en), .act_wr_data(act_wr_data),
        .desc_rd_en(desc_rd_en), .desc_rd_idx(desc_rd_idx),
        .desc_rd_status(desc_rd_status), .desc_rd_buf(desc_rd_buf),
        .desc_wr_en(desc_wr_en), .desc_wr_idx(desc_wr_idx),
        .desc_wr_status(desc_wr_status), .desc_wr_len(desc_wr_len),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .frame_done(frame_done), .missed_count(missed_count)
    );

    // host-side descriptor and buffer model
    logic [15:0] d_stat [8];
    logic [15:0] d_len  [8];
    logic [7:0]  bmem   [512];
    logic        host_init = 1'b0;
    logic        host_ret_en = 1'b0;
    int          host_ret_idx = 0;
    int          rd_seen = 0, wr_seen = 0, nwr = 0, oor = 0;
    int          win_lo = 0, win_hi = 0;

    function automatic logic [15:0] keep_bits(int k);
        return 16'h0400 | ((k == RING - 1) ? 16'h2000 : 16'h0000);
    endfunction

    function automatic logic [7:0] pat(int fid, int i);
        return 8'((fid * 7 + i * 13 + 1) % 256);
    endfunction

    always @(posedge clk) begin
        if (host_init) begin
            for (int k = 0; k < 8; k++) begin
                d_stat[k] <= (k < RING) ? (16'h8000 | keep_bits(k) | 16'h0015) : 16'h0400;
                d_len[k]  <= 16'hFFFF;
            end
        end
        if (host_ret_en) d_stat[host_ret_idx] <= d_stat[host_ret_idx] | 16'h8000;
        if (desc_wr_en) begin
            d_stat[desc_wr_idx] <= desc_wr_status;
            d_len[desc_wr_idx]  <= desc_wr_len;
            wr_seen <= wr_seen + 1;
        end
        if (desc_rd_en) begin
            desc_rd_status <= d_stat[desc_rd_idx];
            desc_rd_buf    <= ADDR_W'(int'(desc_rd_idx) * SPAN);
            rd_seen <= rd_seen + 1;
        end
        if (mem_wr_en) begin
            bmem[mem_wr_addr[8:0]] <= mem_wr_data;
            nwr <= nwr + 1;
            if (int'(mem_wr_addr) < win_lo || int'(mem_wr_addr) >= win_hi) oor <= oor + 1;
        end
    end

    int n_chk = 0, n_err = 0, exp_miss = 0;
    bit finished = 1'b0;

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_frame(int n, logic [4:0] err, int fid);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = pat(fid, i);
            rx_sof   = (i == 0);
            rx_eof   = (i == n - 1);
            rx_err   = (i == n - 1) ? err : 5'h1F;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = '0;
    endtask

    task automatic kick(logic [31:0] v);
        @(negedge clk); act_wr_en = 1'b1; act_wr_data = v;
        @(negedge clk); act_wr_en = 1'b0; act_wr_data = '0;
    endtask

    task automatic give_back(int k);
        @(negedge clk); host_ret_en = 1'b1; host_ret_idx = k;
        @(negedge clk); host_ret_en = 1'b0;
    endtask

    task automatic good_frame(int fid, int n, logic [4:0] err, int k);
        int stored, nwr0, oor0, bad;
        logic [15:0] exp_st;
        stored = (n < BMAX) ? n : BMAX;
        win_lo = k * SPAN; win_hi = k * SPAN + BMAX;
        nwr0 = nwr; oor0 = oor;
        send_frame(n, err, fid);
        // first negedge after the end byte was taken: write-back cycle
        check("R10", "wb cycle desc_wr_en", int'(desc_wr_en), 1);
        check("R10", "no early done", int'(frame_done), 0);
        check("R8", "ring position", int'(desc_wr_idx), k);
        @(negedge clk);
        check("R10", "done pulse", int'(frame_done), 1);
        check("R5", $sformatf("len n=%0d", n), int'(d_len[k]), stored);
        exp_st = keep_bits(k) | {10'd0, err, (n > BMAX) ? 1'b1 : 1'b0};
        check("R7", $sformatf("status n=%0d", n), int'(d_stat[k]), int'(exp_st));
        check("R4", "write count", nwr - nwr0, stored);
        check("R6", "writes outside buffer", oor - oor0, 0);
        bad = 0;
        for (int i = 0; i < stored; i++)
            if (bmem[k * SPAN + i] != pat(fid, i)) bad++;
        check("R4", "byte mismatches", bad, 0);
        @(negedge clk);
        check("R10", "done one cycle", int'(frame_done), 0);
        idle(3);
    endtask

    task automatic drop_frame(int fid, int n, string req);
        int ws0, nwr0;
        ws0 = wr_seen; nwr0 = nwr;
        send_frame(n, 5'd0, fid);
        idle(4);
        if (exp_miss < 3) exp_miss++;
        check("R9", {req, " missed count"}, int'(missed_count), exp_miss);
        check(req, "no write-back", wr_seen - ws0, 0);
        check("R9", "no buffer write", nwr - nwr0, 0);
    endtask

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        int fid;
        host_init = 1'b1;
        idle(5);
        check("R1", "rd_en in reset", int'(desc_rd_en), 0);
        check("R1", "wr_en in reset", int'(desc_wr_en), 0);
        check("R1", "mem_wr in reset", int'(mem_wr_en), 0);
        check("R1", "done in reset", int'(frame_done), 0);
        check("R1", "missed in reset", int'(missed_count), 0);
        @(negedge clk); rst_n = 1'b1; host_init = 1'b0;
        idle(6);
        check("R1", "no fetch before restart", rd_seen, 0);

        drop_frame(900, 10, "R3");              // parked since reset
        kick(32'h0000_0001);
        kick(32'h0100_0001);
        idle(3);
        check("R2", "wrong restart ignored", rd_seen, 0);
        drop_frame(901, 7, "R2");
        kick(32'h0100_0000);
        idle(3);
        check("R2", "restart fetches", rd_seen, 1);

        // length sweep 1..60 over the ring, buffer of 48
        for (int f = 0; f < 60; f++) begin
            good_frame(f, f + 1, 5'((f * 5 + 3) % 32), f % RING);
            give_back(f % RING);
        end

        // fill the whole ring without returning buffers (R3)
        for (int f = 0; f < RING; f++) good_frame(60 + f, 20, 5'd0, f);
        drop_frame(902, 9, "R3");
        drop_frame(903, 9, "R9");               // count saturates at 3
        for (int k = 0; k < RING; k++) give_back(k);
        kick(32'h0100_0000);
        idle(4);
        fid = 70;
        good_frame(fid, 5, 5'd0, 0);
        good_frame(fid + 1, BMAX, 5'h11, 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule